// File: doc/BRIEF.md
# Burst Pull Data Arbiter

This block moves write data from several requesting units toward one memory channel. Each requester pushes commands into its own small command queue. A command carries a start byte address on an 8-byte boundary, a length counted in 8-byte beats, and a tag chosen by the requester. The commands at the heads of the queues compete under a round-robin rule. Once a command wins, it keeps the grant until every one of its beats has moved.

For each beat the block issues one read on a shared source read port. The port returns data one cycle later. The block then hands that data back to the owning requester with a per-requester valid strobe. Between beats it keeps the live command's address and remaining count in registers and rewrites them on every beat. The final beat's valid comes with a done pulse that returns the command's tag. A command with an illegal length is discarded without moving any data, and an error pulse reports which requester it came from.

Control is a two-state sequencer:
- `ST_IDLE` picks a head command. It takes the transition *grant* to `ST_BURST` for a legal command. It takes the transition *drop* back to `ST_IDLE` for an illegal command, or stays when nothing is pending.
- `ST_BURST` issues one beat per cycle. It takes *next beat* back to `ST_BURST`, and *last beat* to `ST_IDLE`, which pops the queue and moves the round-robin pointer.

Top module: `burst_pull_arb`

## Requirements
- R1: While reset is held and in the first cycle after it, `beat_vld`, `done`, `err`, `src_rd_en` and `cmd_full` are all zero. The round-robin pointer starts at requester 0.
- R2: Each requester's commands are served in the order they were pushed. A requester's queue holds FIFO_DEPTH commands. `cmd_full[i]` is high while queue i holds FIFO_DEPTH commands, and a push into a full queue is discarded.
- R3: The pointer names the requester with the highest priority. The first pending head at or after the pointer, in rising index order with wrap-around, wins. When a command finishes or is dropped, the pointer moves to the index after that requester.
- R4: A granted command of N beats issues exactly N reads on N back-to-back cycles, all for its own requester. No other requester is served in between.
- R5: Beat k of a command (k = 0 .. N-1) reads byte address start + 8*k, modulo 2^32, on `src_rd_addr`.
- R6: `beat_vld` is one-hot: bit i belongs to requester i. It is high in exactly the cycle after each read, with `beat_data` equal to the source data and `beat_addr` equal to that beat's address.
- R7: `done` is high together with the final beat's valid and on no other beat, and `done_tag` then equals the command's 4-bit tag.
- R8: A 5-bit beat count of 0 or above 16 is illegal. Such a command is popped without any read and produces a one-cycle `err` with `err_req` set to the requester index. It appears one cycle after the sequencer sees it, and the pointer moves past that requester.
- R9: Counting from the clock edge that writes a command into an empty queue of an idle block, the first beat's valid is high after two further edges. After a `done`, the next queued command's first beat valid comes two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | NREQ | Per-requester command write strobe |
| cmd_addr | input | NREQ*32 | Per-requester start byte address, slice i for requester i |
| cmd_beats | input | NREQ*5 | Per-requester beat count, slice i |
| cmd_tag | input | NREQ*4 | Per-requester command tag, slice i |
| cmd_full | output | NREQ | Queue i is full |
| src_rd_en | output | 1 | Source read request |
| src_rd_req | output | log2(NREQ) | Requester whose buffer is read |
| src_rd_addr | output | 32 | Byte address of the beat read |
| src_rd_data | input | 64 | Source data, valid one cycle after the read |
| beat_vld | output | NREQ | One-hot per-beat valid strobe |
| beat_data | output | 64 | Beat data |
| beat_addr | output | 32 | Beat byte address |
| done | output | 1 | Final beat of a command |
| done_tag | output | 4 | Tag of the finished command |
| err | output | 1 | Illegal command dropped |
| err_req | output | log2(NREQ) | Requester of the dropped command |

## Verification
The cycle that ends a burst is also the cycle in which the sequencer, back in idle, judges the next head under the freshly moved pointer. The final beat's `done` therefore lands in that same cycle as the next arbitration. The bench provokes this by queuing commands for several requesters in one cycle. It then judges both the order in which the `done` tags come out and whether each following burst's first valid appears exactly two cycles after the previous `done`. The same overlap is driven with an illegal head next to a legal one, so that a drop and the following grant run back to back.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 64;
    localparam int BEAT_W    = 5;
    localparam int TAG_W     = 4;
    localparam int MAX_BEATS = 16;
    localparam int STEP      = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] beats;
        logic [TAG_W-1:0]  tag;
    } cmd_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;
endpackage

// File: rtl/bpa_cmd_fifo.sv
module bpa_cmd_fifo
    import bpa_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  cmd_t din,
    input  logic pop,
    output logic full,
    output logic empty,
    output cmd_t head
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    cmd_t          slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      fill <= fill + 1'b1;
            else if (!do_push && do_pop) fill <= fill - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= din;
    end
endmodule

// File: rtl/bpa_rr_arb.sv
module bpa_rr_arb #(
    parameter int NREQ = 4,
    localparam int IW  = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    input  logic            advance,
    input  logic [IW-1:0]   served,
    output logic            gnt_vld,
    output logic [IW-1:0]   gnt_idx
);
    logic [IW-1:0] ptr;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int off = NREQ - 1; off >= 0; off--) begin
            int cand;
            cand = (int'(ptr) + off) % NREQ;
            if (req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (advance) ptr <= (served == IW'(NREQ-1)) ? '0 : served + 1'b1;
    end
endmodule

// File: rtl/bpa_burst_seq.sv
module bpa_burst_seq
    import bpa_pkg::*;
#(
    parameter int NREQ = 4,
    localparam int IW  = $clog2(NREQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_vld,
    input  logic [IW-1:0]     gnt_idx,
    input  cmd_t              sel_cmd,
    input  logic [DATA_W-1:0] src_rd_data,
    output logic              serve,
    output logic [IW-1:0]     serve_idx,
    output logic              src_rd_en,
    output logic [IW-1:0]     src_rd_req,
    output logic [ADDR_W-1:0] src_rd_addr,
    output logic [NREQ-1:0]   beat_vld,
    output logic [DATA_W-1:0] beat_data,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              done,
    output logic [TAG_W-1:0]  done_tag,
    output logic              err,
    output logic [IW-1:0]     err_req
);
    seq_state_e        state, nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic [BEAT_W-1:0] remain;
    logic [TAG_W-1:0]  cur_tag;
    logic [IW-1:0]     cur_req;
    logic              legal, last;

    logic              rsp_vld, rsp_last;
    logic [IW-1:0]     rsp_req;
    logic [ADDR_W-1:0] rsp_addr;
    logic [TAG_W-1:0]  rsp_tag;
    logic              err_q;
    logic [IW-1:0]     err_req_q;

    assign legal = (sel_cmd.beats != '0) && (sel_cmd.beats <= BEAT_W'(MAX_BEATS));
    assign last  = (remain == BEAT_W'(1));

    // next-state: grant / drop in idle, next beat / last beat in burst
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (gnt_vld && legal) nxt = ST_BURST;
            ST_BURST: if (last)             nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // live command and read-response pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remain    <= '0;
            cur_tag   <= '0;
            cur_req   <= '0;
            rsp_vld   <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_req   <= '0;
            rsp_addr  <= '0;
            rsp_tag   <= '0;
            err_q     <= 1'b0;
            err_req_q <= '0;
        end else begin
            rsp_vld <= 1'b0;
            err_q   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (gnt_vld && legal) begin
                        cur_addr <= sel_cmd.addr;
                        remain   <= sel_cmd.beats;
                        cur_tag  <= sel_cmd.tag;
                        cur_req  <= gnt_idx;
                    end else if (gnt_vld) begin
                        err_q     <= 1'b1;
                        err_req_q <= gnt_idx;
                    end
                end
                ST_BURST: begin
                    cur_addr <= cur_addr + ADDR_W'(STEP);
                    remain   <= remain - 1'b1;
                    rsp_vld  <= 1'b1;
                    rsp_last <= last;
                    rsp_req  <= cur_req;
                    rsp_addr <= cur_addr;
                    rsp_tag  <= cur_tag;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        src_rd_en   = (state == ST_BURST);
        src_rd_req  = cur_req;
        src_rd_addr = cur_addr;
        serve       = (state == ST_BURST) ? last : (gnt_vld && !legal);
        serve_idx   = (state == ST_BURST) ? cur_req : gnt_idx;
        beat_vld    = rsp_vld ? (NREQ'(1) << rsp_req) : '0;
        beat_data   = rsp_vld ? src_rd_data : '0;
        beat_addr   = rsp_addr;
        done        = rsp_vld && rsp_last;
        done_tag    = rsp_tag;
        err         = err_q;
        err_req     = err_req_q;
    end
endmodule

// File: rtl/burst_pull_arb.sv
module burst_pull_arb
    import bpa_pkg::*;
#(
    parameter int NREQ       = 4,
    parameter int FIFO_DEPTH = 4,
    localparam int IW        = $clog2(NREQ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        cmd_push,
    input  logic [NREQ*ADDR_W-1:0] cmd_addr,
    input  logic [NREQ*BEAT_W-1:0] cmd_beats,
    input  logic [NREQ*TAG_W-1:0]  cmd_tag,
    output logic [NREQ-1:0]        cmd_full,
    output logic                   src_rd_en,
    output logic [IW-1:0]          src_rd_req,
    output logic [ADDR_W-1:0]      src_rd_addr,
    input  logic [DATA_W-1:0]      src_rd_data,
    output logic [NREQ-1:0]        beat_vld,
    output logic [DATA_W-1:0]      beat_data,
    output logic [ADDR_W-1:0]      beat_addr,
    output logic                   done,
    output logic [TAG_W-1:0]       done_tag,
    output logic                   err,
    output logic [IW-1:0]          err_req
);
    cmd_t            heads [NREQ];
    logic [NREQ-1:0] pend;
    logic            serve, gnt_vld;
    logic [IW-1:0]   serve_idx, gnt_idx;

    for (genvar g = 0; g < NREQ; g++) begin : g_q
        cmd_t din;
        logic empty;
        assign din.addr  = cmd_addr[g*ADDR_W +: ADDR_W];
        assign din.beats = cmd_beats[g*BEAT_W +: BEAT_W];
        assign din.tag   = cmd_tag[g*TAG_W +: TAG_W];
        assign pend[g]   = !empty;

        bpa_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (cmd_push[g]),
            .din   (din),
            .pop   (serve && (serve_idx == IW'(g))),
            .full  (cmd_full[g]),
            .empty (empty),
            .head  (heads[g])
        );
    end

    bpa_rr_arb #(.NREQ(NREQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pend),
        .advance (serve),
        .served  (serve_idx),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    bpa_burst_seq #(.NREQ(NREQ)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .gnt_vld     (gnt_vld),
        .gnt_idx     (gnt_idx),
        .sel_cmd     (heads[gnt_idx]),
        .src_rd_data (src_rd_data),
        .serve       (serve),
        .serve_idx   (serve_idx),
        .src_rd_en   (src_rd_en),
        .src_rd_req  (src_rd_req),
        .src_rd_addr (src_rd_addr),
        .beat_vld    (beat_vld),
        .beat_data   (beat_data),
        .beat_addr   (beat_addr),
        .done        (done),
        .done_tag    (done_tag),
        .err         (err),
        .err_req     (err_req)
    );
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker
    import bpa_pkg::*;
#(
    parameter int NREQ = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_rd_en,
    input logic [NREQ-1:0]   beat_vld,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              done,
    input logic              err
);
    assert_vld_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(beat_vld));

    assert_read_gives_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |=> (beat_vld != '0));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((beat_vld != '0) && ($past(beat_vld) != '0) && !$past(done))
        |-> (beat_addr == $past(beat_addr) + ADDR_W'(STEP)));

    assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((beat_vld != '0) && ($past(beat_vld) != '0) && !$past(done))
        |-> (beat_vld == $past(beat_vld)));

    assert_done_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (beat_vld != '0));

    assert_drop_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !src_rd_en);
endmodule

bind burst_pull_arb bpa_checker #(.NREQ(NREQ)) u_chk (.*);

// File: tb/burst_pull_arb_test.sv
module burst_pull_arb_test;
    localparam int NREQ = 4;
    localparam int DEP  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NREQ-1:0]   cmd_push = '0;
    logic [NREQ*32-1:0] cmd_addr = '0;
    logic [NREQ*5-1:0] cmd_beats = '0;
    logic [NREQ*4-1:0] cmd_tag = '0;
    logic [NREQ-1:0]   cmd_full;
    logic              src_rd_en;
    logic [1:0]        src_rd_req;
    logic [31:0]       src_rd_addr;
    logic [63:0]       src_rd_data = '0;
    logic [NREQ-1:0]   beat_vld;
    logic [63:0]       beat_data;
    logic [31:0]       beat_addr;
    logic              done;
    logic [3:0]        done_tag;
    logic              err;
    logic [1:0]        err_req;

    burst_pull_arb #(.NREQ(NREQ), .FIFO_DEPTH(DEP)) uut (.*);

    always #10 clk = ~clk;

    function automatic logic [63:0] src_word(input logic [31:0] a);
        return {a ^ 32'h5A5A_0F0F, a};
    endfunction

    always @(posedge clk) src_rd_data <= src_rd_en ? src_word(src_rd_addr) : 64'h0;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // observation log
    int          lg_n = 0, dn_n = 0, er_n = 0;
    logic [3:0]  lg_vld  [256];
    logic [31:0] lg_addr [256];
    logic [63:0] lg_data [256];
    logic        lg_done [256];
    logic [3:0]  lg_tag  [256];
    int          lg_cyc  [256];
    int          dn_req  [64];
    int          dn_tag  [64];
    int          dn_cyc  [64];
    int          dn_lg   [64];
    int          er_req  [64];
    int          er_cyc  [64];

    always @(negedge clk) begin
        if (rst_n && beat_vld != '0) begin
            lg_vld[lg_n]  = beat_vld;
            lg_addr[lg_n] = beat_addr;
            lg_data[lg_n] = beat_data;
            lg_done[lg_n] = done;
            lg_tag[lg_n]  = done_tag;
            lg_cyc[lg_n]  = cyc;
            if (done) begin
                for (int i = 0; i < NREQ; i++) if (beat_vld[i]) dn_req[dn_n] = i;
                dn_tag[dn_n] = int'(done_tag);
                dn_cyc[dn_n] = cyc;
                dn_lg[dn_n]  = lg_n;
                dn_n++;
            end
            lg_n++;
        end
        if (rst_n && err) begin
            er_req[er_n] = int'(err_req);
            er_cyc[er_n] = cyc;
            er_n++;
        end
    end

    int checks = 0, fails = 0;
    int push_cyc = 0;
    bit finished = 0;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic set_cmd(input int r, input logic [31:0] a, input logic [4:0] b, input logic [3:0] t);
        cmd_push[r]            = 1'b1;
        cmd_addr[r*32 +: 32]   = a;
        cmd_beats[r*5 +: 5]    = b;
        cmd_tag[r*4 +: 4]      = t;
    endtask

    task automatic strobe();
        @(posedge clk);
        @(negedge clk);
        cmd_push = '0;
        push_cyc = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  r;
        logic [31:0] a;
        logic [4:0]  b;
        logic [3:0]  t;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h0000_1000, 5'd1,  4'd3},
        '{2'd1, 32'h0000_2008, 5'd4,  4'd5},
        '{2'd2, 32'hFFFF_FFF0, 5'd3,  4'd9},
        '{2'd3, 32'h0000_0000, 5'd16, 4'd15},
        '{2'd1, 32'h0000_0040, 5'd2,  4'd0},
        '{2'd0, 32'h8000_0000, 5'd7,  4'd12}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base, db, eb;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 beat_vld in reset", 64'(beat_vld), 64'h0);
        chk("R1 src_rd_en in reset", 64'(src_rd_en), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done/err after reset", {62'h0, done, err}, 64'h0);
        chk("R1 cmd_full after reset", 64'(cmd_full), 64'h0);

        // table walk: single commands
        for (int v = 0; v < NV; v++) begin
            base = lg_n;
            db   = dn_n;
            set_cmd(int'(VEC[v].r), VEC[v].a, VEC[v].b, VEC[v].t);
            strobe();
            idle(int'(VEC[v].b) + 5);
            chk("R4 beat count", 64'(lg_n - base), 64'(VEC[v].b));
            chk("R9 first beat latency", 64'(lg_cyc[base]), 64'(push_cyc + 2));
            chk("R7 one done", 64'(dn_n - db), 64'h1);
            for (int k = 0; k < int'(VEC[v].b); k++) begin
                logic [31:0] ea;
                ea = VEC[v].a + 32'(8 * k);
                chk("R5 beat address", 64'(lg_addr[base+k]), 64'(ea));
                chk("R6 beat data", lg_data[base+k], src_word(ea));
                chk("R6 beat strobe", 64'(lg_vld[base+k]), 64'(4'b0001 << VEC[v].r));
                chk("R4 back-to-back", 64'(lg_cyc[base+k]), 64'(lg_cyc[base] + k));
                chk("R7 done only on last", 64'(lg_done[base+k]), 64'(k == int'(VEC[v].b) - 1));
            end
            chk("R7 done tag", 64'(lg_tag[base + int'(VEC[v].b) - 1]), 64'(VEC[v].t));
        end

        // R3: pointer is 1 after last vector (requester 0 served); push 0,1,3 -> 1,3,0
        db = dn_n;
        set_cmd(0, 32'h100, 5'd2, 4'd8);
        set_cmd(1, 32'h200, 5'd2, 4'd9);
        set_cmd(3, 32'h300, 5'd2, 4'd11);
        strobe();
        idle(20);
        chk("R3 order A count", 64'(dn_n - db), 64'h3);
        chk("R3 order A first", 64'(dn_req[db]),   64'h1);
        chk("R3 order A second", 64'(dn_req[db+1]), 64'h3);
        chk("R3 order A third", 64'(dn_req[db+2]), 64'h0);
        for (int k = 0; k < 2; k++)
            chk("R9 gap after done", 64'(lg_cyc[dn_lg[db+k] + 1]), 64'(dn_cyc[db+k] + 2));

        // pointer back at 1; push 0,2,3 -> 2,3,0
        db = dn_n;
        set_cmd(0, 32'h400, 5'd1, 4'd1);
        set_cmd(2, 32'h500, 5'd3, 4'd2);
        set_cmd(3, 32'h600, 5'd1, 4'd3);
        strobe();
        idle(20);
        chk("R3 order B first", 64'(dn_tag[db]),   64'h2);
        chk("R3 order B second", 64'(dn_tag[db+1]), 64'h3);
        chk("R3 order B third", 64'(dn_tag[db+2]), 64'h1);
        chk("R9 gap after done B", 64'(lg_cyc[dn_lg[db] + 1]), 64'(dn_cyc[db] + 2));

        // R8: zero-length and oversize commands dropped
        base = lg_n; eb = er_n;
        set_cmd(2, 32'h700, 5'd0, 4'd4);
        strobe();
        idle(6);
        chk("R8 zero count err", 64'(er_n - eb), 64'h1);
        chk("R8 err requester", 64'(er_req[eb]), 64'h2);
        chk("R8 err timing", 64'(er_cyc[eb]), 64'(push_cyc + 1));
        chk("R8 no data for zero", 64'(lg_n - base), 64'h0);

        base = lg_n; eb = er_n;
        set_cmd(2, 32'h780, 5'd17, 4'd4);
        strobe();
        idle(6);
        chk("R8 oversize err", 64'(er_n - eb), 64'h1);
        chk("R8 no data for oversize", 64'(lg_n - base), 64'h0);

        // illegal head on 1 next to legal 2, pointer at 3: drop 1 then serve 2
        base = lg_n; eb = er_n; db = dn_n;
        set_cmd(1, 32'h800, 5'd0, 4'd6);
        set_cmd(2, 32'h900, 5'd2, 4'd7);
        strobe();
        idle(8);
        chk("R8 mixed err requester", 64'(er_req[eb]), 64'h1);
        chk("R8 mixed one err", 64'(er_n - eb), 64'h1);
        chk("R3 grant after drop", 64'(lg_cyc[base]), 64'(push_cyc + 3));
        chk("R3 served after drop", 64'(dn_tag[db]), 64'h7);

        // R2: fill requester 3, fifth push discarded, order preserved
        db = dn_n;
        for (int p = 0; p < DEP + 1; p++) begin
            set_cmd(3, 32'h1_0000 + 32'(p * 'h100), 5'd16, 4'(p + 1));
            strobe();
            if (p == DEP - 1) chk("R2 full flag", 64'(cmd_full[3]), 64'h1);
        end
        idle(90);
        chk("R2 full push dropped", 64'(dn_n - db), 64'(DEP));
        for (int p = 0; p < DEP; p++) begin
            chk("R2 push order", 64'(dn_tag[db+p]), 64'(p + 1));
            chk("R2 burst start", 64'(lg_addr[dn_lg[db+p] - 15]), 64'(32'h1_0000 + 32'(p * 'h100)));
        end
        chk("R2 full cleared", 64'(cmd_full[3]), 64'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule